// File: doc/BRIEF.md
# Calendar Real-Time Clock with Hour/Minute Alarm

This block keeps wall-clock time from seconds up to a two-digit year. A single-cycle tick enable at 1024 Hz is divided by eight into 1/128-second steps. A sub-second field counts down the steps left before the next whole second. When 128 steps have passed, the second advances. The carry then ripples through minutes, hours, date, month and year, and the day of week advances whenever the date does. Month lengths follow the calendar. A year whose value is a multiple of four, zero included, is a leap year.

Software uses a simple register port, with a write path and a combinational read path. To set the time, it sets a freeze bit. This holds a shadow copy of the time fields, which software then edits. Clearing the freeze bit commits the shadow: the copy lands in the live counter on the next tick. The freeze bit keeps reading 1 until that copy has happened. Each time-field write is accepted only if the register write just before it went to an unlock address. A separate comparator raises a one-cycle interrupt when the live hour and minute become equal to a programmed target.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 on day-of-week 1, date 1, month 1, year 0. The sub-second field reads 127, the control register reads 0 and both alarm targets read 0.
- R2: Register map, used for both reads and writes: 0 sub-second (read-only), 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year, 8 alarm minute, 9 alarm hour, 10 control (bit 0 is freeze), 11 unlock. The sub-second field drops by one every 8 ticks, from 127 to 0. The seconds field advances when the step that finds the field at 0 arrives, so 1024 ticks make one second.
- R3: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and advance the date. Day of week runs 1 to 7 and goes from 7 back to 1 whenever the date advances.
- R4: Months 4, 6, 9 and 11 end after date 30. All other months except February end after date 31. Past the end of the month, the date returns to 1 and the month advances.
- R5: February ends after date 29 when the year is divisible by 4, year 0 included, and after date 28 otherwise.
- R6: Month 12 wraps to month 1 and advances the year. Year 99 wraps to 0.
- R7: While control bit 0 is set, reads of addresses 1 to 7 return the shadow copy, and accepted field writes change only that shadow.
- R8: Writing 0 to control bit 0 while it is set arms a commit. The shadow is loaded into the live time on the next tick, and that tick also restarts the sub-second count at 127. Control bit 0 reads 1 until the load has happened.
- R9: A write to addresses 1 to 7 takes effect only when the register write immediately before it went to address 11. Any single register write uses up the unlock.
- R10: The alarm output pulses high for exactly one cycle. The pulse comes one cycle after the live hour and minute become equal to the alarm targets (addresses 9 and 8). It does not repeat while they stay equal.
- R11: A time-field write made while control bit 0 is clear has no effect, even when it is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1k | input | 1 | Single-cycle enable at 1024 Hz |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
Register writes and the read-back of every register are visible in the cycle after the write edge, because reads are combinational. A commit shows up on the first tick after the freeze bit is cleared. It is due within four clock cycles, since the bench issues one tick every four cycles. Calendar carries are due a whole number of seconds after that commit, at 4096 clock cycles per second. The bench therefore samples half a second away from each boundary, and reads the sub-second field with a tolerance of one step. The alarm pulse is counted at every falling edge, so a pulse that lasts one cycle is counted exactly once.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_SUB     = 4'd0,
        A_SEC     = 4'd1,
        A_MIN     = 4'd2,
        A_HR      = 4'd3,
        A_DOW     = 4'd4,
        A_DATE    = 4'd5,
        A_MON     = 4'd6,
        A_YR      = 4'd7,
        A_ALM_MIN = 4'd8,
        A_ALM_HR  = 4'd9,
        A_CTRL    = 4'd10,
        A_UNLOCK  = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hr;
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] mon;
        logic [7:0] yr;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{sec: 6'd0, min: 6'd0, hr: 5'd0,
                                         dow: 3'd1, date: 5'd1, mon: 4'd1, yr: 8'd0};

    // Last valid date of a month; leap rule is a plain divisible-by-four test.
    function automatic logic [4:0] month_last_day(input logic [3:0] mon, input logic [7:0] yr);
        case (mon)
            4'd2:                       return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
            default:                    return 5'd31;
        endcase
    endfunction

    function automatic logic is_time_field(input logic [ADDR_W-1:0] a);
        return (a >= A_SEC) && (a <= A_YR);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter  int TICKS_PER_STEP = 8,
    parameter  int STEPS_PER_SEC  = 128,
    localparam int SUB_W          = $clog2(STEPS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [SUB_W-1:0] sub,
    output logic             sec_pulse
);
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(STEPS_PER_SEC - 1);

    logic             step;
    logic [SUB_W-1:0] sub_d, sub_q;

    generate
        if (TICKS_PER_STEP == 1) begin : g_nodiv
            assign step = tick;
        end else begin : g_div
            localparam int              DIV_W   = $clog2(TICKS_PER_STEP);
            localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICKS_PER_STEP - 1);
            logic [DIV_W-1:0] div_d, div_q;

            always_comb begin
                div_d = div_q;
                if (restart)   div_d = '0;
                else if (tick) div_d = (div_q == DIV_TOP) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign step = tick && (div_q == DIV_TOP);
        end
    endgenerate

    always_comb begin
        sub_d = sub_q;
        if (restart)   sub_d = SUB_TOP;
        else if (step) sub_d = (sub_q == '0) ? SUB_TOP : sub_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= SUB_TOP;
        else        sub_q <= sub_d;
    end

    assign sub       = sub_q;
    assign sec_pulse = step && (sub_q == '0) && !restart;
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    always_comb begin
        nxt = cur;
        if (cur.sec != 6'd59) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cur.min != 6'd59) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cur.hr != 5'd23) begin
                    nxt.hr = cur.hr + 5'd1;
                end else begin
                    nxt.hr  = 5'd0;
                    nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
                    if (cur.date < month_last_day(cur.mon, cur.yr)) begin
                        nxt.date = cur.date + 5'd1;
                    end else begin
                        nxt.date = 5'd1;
                        if (cur.mon != 4'd12) begin
                            nxt.mon = cur.mon + 4'd1;
                        end else begin
                            nxt.mon = 4'd1;
                            nxt.yr  = (cur.yr == 8'd99) ? 8'd0 : cur.yr + 8'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter  int TICKS_PER_STEP = 8,
    parameter  int STEPS_PER_SEC  = 128,
    localparam int SUB_W          = $clog2(STEPS_PER_SEC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              alarm_irq
);
    typedef struct packed {
        rtc_time_t  live;
        rtc_time_t  shadow;
        logic [5:0] amin;
        logic [4:0] ahr;
        logic       freeze;
        logic       pending;
        logic       unlock;
        logic       match;
        logic       irq;
    } state_t;

    // match starts high so a target equal to the reset time does not pulse.
    localparam state_t ST_RESET = '{live: TIME_RESET, shadow: TIME_RESET,
                                    amin: 6'd0, ahr: 5'd0, freeze: 1'b0,
                                    pending: 1'b0, unlock: 1'b0, match: 1'b1, irq: 1'b0};

    state_t st_d, st_q;

    rtc_time_t        live_q, shadow_q, live_next, view;
    logic             freeze_q, pending_q, unlock_q;
    logic [SUB_W-1:0] sub;
    logic             sec_pulse, commit;

    assign live_q    = st_q.live;
    assign shadow_q  = st_q.shadow;
    assign freeze_q  = st_q.freeze;
    assign pending_q = st_q.pending;
    assign unlock_q  = st_q.unlock;
    assign commit    = pending_q && tick_1k;

    rtc_prescaler #(
        .TICKS_PER_STEP (TICKS_PER_STEP),
        .STEPS_PER_SEC  (STEPS_PER_SEC)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1k),
        .restart   (commit),
        .sub       (sub),
        .sec_pulse (sec_pulse)
    );

    rtc_advance u_adv (
        .cur (live_q),
        .nxt (live_next)
    );

    always_comb begin
        st_d = st_q;

        if (commit) begin
            st_d.live    = shadow_q;
            st_d.pending = 1'b0;
        end else if (sec_pulse) begin
            st_d.live = live_next;
        end

        if (!freeze_q && !pending_q) st_d.shadow = live_q;

        st_d.match = (live_q.min == st_q.amin) && (live_q.hr == st_q.ahr);
        st_d.irq   = st_d.match && !st_q.match;

        if (wr_en) begin
            st_d.unlock = (wr_addr == A_UNLOCK);
            if (unlock_q && freeze_q) begin
                case (wr_addr)
                    A_SEC:   st_d.shadow.sec  = wr_data[5:0];
                    A_MIN:   st_d.shadow.min  = wr_data[5:0];
                    A_HR:    st_d.shadow.hr   = wr_data[4:0];
                    A_DOW:   st_d.shadow.dow  = wr_data[2:0];
                    A_DATE:  st_d.shadow.date = wr_data[4:0];
                    A_MON:   st_d.shadow.mon  = wr_data[3:0];
                    A_YR:    st_d.shadow.yr   = wr_data;
                    default: ;
                endcase
            end
            case (wr_addr)
                A_ALM_MIN: st_d.amin = wr_data[5:0];
                A_ALM_HR:  st_d.ahr  = wr_data[4:0];
                A_CTRL: begin
                    if (wr_data[0]) begin
                        st_d.freeze  = 1'b1;
                        st_d.pending = 1'b0;
                    end else if (freeze_q) begin
                        st_d.freeze  = 1'b0;
                        st_d.pending = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        view    = (freeze_q || pending_q) ? shadow_q : live_q;
        rd_data = '0;
        case (rd_addr)
            A_SUB:     rd_data[SUB_W-1:0] = sub;
            A_SEC:     rd_data[5:0] = view.sec;
            A_MIN:     rd_data[5:0] = view.min;
            A_HR:      rd_data[4:0] = view.hr;
            A_DOW:     rd_data[2:0] = view.dow;
            A_DATE:    rd_data[4:0] = view.date;
            A_MON:     rd_data[3:0] = view.mon;
            A_YR:      rd_data      = view.yr;
            A_ALM_MIN: rd_data[5:0] = st_q.amin;
            A_ALM_HR:  rd_data[4:0] = st_q.ahr;
            A_CTRL:    rd_data[0]   = freeze_q || pending_q;
            default:   ;
        endcase
    end

    assign alarm_irq = st_q.irq;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq,
    input rtc_time_t         live,
    input rtc_time_t         shadow,
    input logic              freeze,
    input logic              pending,
    input logic              unlock,
    input logic [5:0]        amin,
    input logic [4:0]        ahr
);
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((live.min == amin) && (live.hr == ahr)));

    p_field_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live.sec < 6'd60) && (live.min < 6'd60) && (live.hr < 5'd24) &&
        (live.dow >= 3'd1) && (live.dow <= 3'd7));

    p_locked_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_time_field(wr_addr) && !unlock && freeze) |=> $stable(shadow));

    p_unlock_used_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != A_UNLOCK)) |=> !unlock);

    p_commit_waits_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !tick) |=> (pending || freeze));

    p_commit_loads_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tick) |=> (live == $past(shadow)));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1k),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .irq     (alarm_irq),
    .live    (live_q),
    .shadow  (shadow_q),
    .freeze  (freeze_q),
    .pending (pending_q),
    .unlock  (unlock_q),
    .amin    (st_q.amin),
    .ahr     (st_q.ahr)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
    import rtc_pkg::*;

    logic       clk = 1'b0, rst_n = 1'b0, tick_1k = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    wire  [7:0] rd_data;
    wire        alarm_irq;

    always #4 clk = ~clk;

    rtc_calendar u_dut (
        .clk (clk), .rst_n (rst_n), .tick_1k (tick_1k), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data), .rd_addr (rd_addr),
        .rd_data (rd_data), .alarm_irq (alarm_irq)
    );

    int n_checks = 0, n_fail = 0, irq_cnt = 0;
    bit tick_run = 0, mon_busy = 0, done = 0;

    typedef struct { logic [3:0] addr; int exp; int tol; string tag; } exp_t;
    exp_t sb_q[$];

    // one tick every four clocks while enabled
    initial begin : tick_gen
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            tick_1k = tick_run && (ph % 4 == 0);
            ph++;
        end
    end

    initial forever begin
        @(negedge clk);
        if (alarm_irq) irq_cnt++;
    end

    // monitor: pops expected reads and compares
    initial forever begin
        @(negedge clk);
        if (sb_q.size() > 0) begin
            exp_t it;
            int   diff;
            mon_busy = 1;
            it = sb_q.pop_front();
            rd_addr = it.addr;
            #1;
            diff = int'(rd_data) - it.exp;
            n_checks++;
            if (diff > it.tol || diff < -it.tol) begin
                n_fail++;
                $display("FAIL %s: addr %0d got %0d expected %0d", it.tag, it.addr, rd_data, it.exp);
            end
            mon_busy = 0;
        end
    end

    task automatic expect_rd(input logic [3:0] a, input int e, input string tag, input int tol = 0);
        exp_t it;
        it.addr = a; it.exp = e; it.tol = tol; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_field(input logic [3:0] a, input int d);
        wr(A_UNLOCK, 0);
        wr(a, d);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_time(input int s, input int m, input int h, input int dw,
                               input int dt, input int mo, input int y, input string tag);
        expect_rd(A_SEC, s, tag);   expect_rd(A_MIN, m, tag);  expect_rd(A_HR, h, tag);
        expect_rd(A_DOW, dw, tag);  expect_rd(A_DATE, dt, tag);
        expect_rd(A_MON, mo, tag);  expect_rd(A_YR, y, tag);
    endtask

    task automatic set_time(input int s, input int m, input int h, input int dw,
                            input int dt, input int mo, input int y);
        tick_run = 0;
        cycles(4);
        wr(A_CTRL, 1);
        wr_field(A_SEC, s);  wr_field(A_MIN, m);  wr_field(A_HR, h);
        wr_field(A_DOW, dw); wr_field(A_DATE, dt); wr_field(A_MON, mo);
        wr_field(A_YR, y);
        wr(A_CTRL, 0);
        cycles(3);
        expect_rd(A_CTRL, 1, "R8 pending until tick");
        tick_run = 1;
        cycles(10);
        expect_rd(A_CTRL, 0, "R8 commit done");
        expect_rd(A_SUB, 127, "R8 sub restart");
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin : watchdog
        cycles(190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin : driver
        int base;
        cycles(5);
        rst_n = 1'b1;
        cycles(2);

        // R1 reset state
        expect_time(0, 0, 0, 1, 1, 1, 0, "R1 reset");
        expect_rd(A_SUB, 127, "R1 sub");
        expect_rd(A_CTRL, 0, "R1 ctrl");
        expect_rd(A_ALM_MIN, 0, "R1 alarm min");
        expect_rd(A_ALM_HR, 0, "R1 alarm hr");

        wr(A_ALM_MIN, 30);
        wr(A_ALM_HR, 12);
        expect_rd(A_ALM_MIN, 30, "R10 target min");
        expect_rd(A_ALM_HR, 12, "R10 target hr");

        // R11 unlocked write while not frozen
        wr_field(A_SEC, 5);
        expect_rd(A_SEC, 0, "R11 unfrozen write ignored");

        // R9 / R7 unlock behaviour on the shadow
        wr(A_CTRL, 1);
        expect_rd(A_CTRL, 1, "R7 freeze reads one");
        wr_field(A_SEC, 10);
        expect_rd(A_SEC, 10, "R7 shadow written");
        wr(A_SEC, 20);
        expect_rd(A_SEC, 10, "R9 no unlock");
        wr(A_UNLOCK, 0); wr(A_SEC, 30); wr(A_SEC, 40);
        expect_rd(A_SEC, 30, "R9 unlock used once");
        wr(A_UNLOCK, 0); wr(A_CTRL, 1); wr(A_SEC, 50);
        expect_rd(A_SEC, 30, "R9 unlock used by other write");
        wr(A_CTRL, 0);
        expect_rd(A_CTRL, 1, "R8 pending without ticks");

        // R2 sub-second countdown and second step
        set_time(58, 14, 10, 3, 15, 6, 21);
        cycles(2048);
        expect_rd(A_SUB, 63, "R2 sub half second", 1);
        expect_rd(A_SEC, 58, "R2 before boundary");
        cycles(4096);
        expect_rd(A_SEC, 59, "R2 one second");
        cycles(4096);
        expect_time(0, 15, 10, 3, 15, 6, 21, "R3 minute carry");

        set_time(59, 59, 23, 7, 10, 6, 21);
        cycles(6144);
        expect_time(0, 0, 0, 1, 11, 6, 21, "R3 day and dow wrap");

        set_time(59, 59, 23, 2, 30, 4, 22);
        cycles(6144);
        expect_time(0, 0, 0, 3, 1, 5, 22, "R4 30-day month");

        set_time(59, 59, 23, 4, 30, 5, 22);
        cycles(6144);
        expect_time(0, 0, 0, 5, 31, 5, 22, "R4 31-day month");

        set_time(59, 59, 23, 7, 28, 2, 24);
        cycles(6144);
        expect_time(0, 0, 0, 1, 29, 2, 24, "R5 leap Feb 29");

        set_time(59, 59, 23, 1, 29, 2, 24);
        cycles(6144);
        expect_time(0, 0, 0, 2, 1, 3, 24, "R5 leap Feb end");

        set_time(59, 59, 23, 5, 28, 2, 23);
        cycles(6144);
        expect_time(0, 0, 0, 6, 1, 3, 23, "R5 common Feb end");

        set_time(59, 59, 23, 3, 28, 2, 0);
        cycles(6144);
        expect_time(0, 0, 0, 4, 29, 2, 0, "R5 year zero leap");

        set_time(59, 59, 23, 6, 31, 12, 99);
        cycles(6144);
        expect_time(0, 0, 0, 7, 1, 1, 0, "R6 year wrap");

        check_eq("R10 no pulse off target", irq_cnt, 0);

        // R10 alarm pulse
        base = irq_cnt;
        set_time(59, 29, 12, 2, 1, 3, 22);
        check_eq("R10 no pulse before match", irq_cnt - base, 0);
        cycles(6144);
        expect_rd(A_MIN, 30, "R10 minute reached");
        check_eq("R10 one pulse on match", irq_cnt - base, 1);
        cycles(4096);
        check_eq("R10 no repeat while matching", irq_cnt - base, 1);

        done = 1;
        report();
        $finish;
    end
endmodule